// File: doc/BRIEF.md
# Two-Channel Byte-Loaded Converter Code Register

This block is the digital front end of a two-channel 12-bit converter that is fed from an 8-bit parallel bus. Each channel has two registers. The staging register is filled by two narrow writes: an 8-bit low part and a 4-bit high part. The output register holds the code that drives the analog section, which is outside this block.

The host chooses the channel, the half and the data, then raises the write strobe for one clock. The two halves may arrive in either order. The mode input sets when a staged code reaches the output register:

- In automatic mode, the code moves on the clock edge that completes the pair of halves.
- In strobed mode, the staged codes stay where they are until the load strobe rises. Both channels then move together on that one edge.

All inputs are sampled on the rising clock edge. The reset is synchronous and active low.

Top module: `dual_dac_front`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both staging registers, both output codes and all half-tracking state are cleared to zero.
- R2: A write is taken on a rising edge with `wr_en` high. It goes only to the channel chosen by `chan_sel` (0 = channel A, 1 = channel B). The other channel's registers and output are left unchanged.
- R3: With `byte_hi` = 0, a write loads `din[7:0]` into code bits 7:0. With `byte_hi` = 1, a write loads `din[3:0]` into code bits 11:8, and `din[7:4]` has no effect.
- R4: A full code may be written low part first or high part first, and both orders give the same output code.
- R5: With `auto_mode` = 1, a channel's output code takes the completed 12-bit value from the cycle after the edge that captures the second, different half. A single half, or the same half written twice, leaves the output unchanged.
- R6: With `auto_mode` = 0, the output codes hold their values through any number of writes until the load strobe rises.
- R7: On a rising edge of `ld_strobe`, both channels copy their staging registers to their outputs on the same clock edge. This also clears the half-tracking of both channels.
- R8: A load strobe held high for several cycles causes exactly one transfer. Writes made while it stays high do not reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe; data captured while high |
| chan_sel | input | 1 | Target channel: 0 = A, 1 = B |
| byte_hi | input | 1 | Half select: 0 = low 8 bits, 1 = high 4 bits |
| din | input | 8 | Parallel data bus (right-justified) |
| ld_strobe | input | 1 | Load strobe; rising edge transfers both channels |
| auto_mode | input | 1 | 1 = transfer when a pair of halves completes, 0 = transfer on load strobe |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |

## Verification
The hardest case to reach is the load strobe held high while new data is written. It should give exactly one transfer, yet the staging register keeps changing under the still-high strobe.

The bench first raises the strobe and leaves it high. It then writes a fresh low part to channel A and confirms that the output keeps the old code. It then drops the strobe, raises it again, and confirms that the new value appears.

A second case is a repeated write of the same half in automatic mode. The bench writes the low part twice and checks that no transfer occurs until the high part arrives.

// File: rtl/dacif_pkg.sv
// Shared constants and types for the two-channel converter front end.
// Assumes exactly two channels; widths are overridable per instance.
package dacif_pkg;
    localparam int DEF_CODE_W = 12;
    localparam int DEF_BUS_W  = 8;
    localparam int NUM_CH     = 2;

    // Which half of a staged code a write targets.
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/dacif_load_edge.sv
// Turns a level load strobe into a one-cycle pulse on its rising edge.
// Assumes ld_strobe is synchronous to clk.
module dacif_load_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_strobe,
    output logic ld_pulse
);
    logic ld_prev;

    // Remember last cycle's strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_prev <= 1'b0;
        else        ld_prev <= ld_strobe;
    end

    // Pulse only on a low-to-high change.
    assign ld_pulse = ld_strobe & ~ld_prev;
endmodule

// File: rtl/dacif_in_reg.sv
// Staging register for one channel, filled from two narrow writes in any
// order. It tracks which halves have arrived since the last transfer and
// flags the edge that completes a pair while automatic mode is selected.
// Assumes CODE_W > BUS_W and that the high part is right-justified on the bus.
module dacif_in_reg
    import dacif_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int BUS_W  = DEF_BUS_W,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              chan_sel,
    input  logic              byte_hi,
    input  logic [BUS_W-1:0]  din,
    input  logic              auto_mode,
    input  logic              ld_pulse,
    output logic [CODE_W-1:0] word_q,
    output logic [CODE_W-1:0] word_nx,
    output logic              pair_done
);
    localparam int HI_W = CODE_W - BUS_W;

    logic  hit;
    half_e half;
    logic  have_lo, have_hi;
    logic  have_lo_nx, have_hi_nx;

    assign hit  = wr_en && (chan_sel == CH_IDX[0]);
    assign half = half_e'(byte_hi);

    // Merge the write data into the selected half of the staged word.
    always_comb begin
        word_nx = word_q;
        if (hit) begin
            if (half == HALF_HI) word_nx[CODE_W-1:BUS_W] = din[HI_W-1:0];
            else                 word_nx[BUS_W-1:0]      = din;
        end
    end

    // A pair completes when this write supplies the half not yet present.
    assign pair_done = hit && auto_mode &&
                       ((half == HALF_HI) ? have_lo : have_hi);

    // Update the half-tracking flags: clear on any transfer, then set by a write.
    always_comb begin
        have_lo_nx = have_lo;
        have_hi_nx = have_hi;
        if (pair_done) begin
            have_lo_nx = 1'b0;
            have_hi_nx = 1'b0;
        end else begin
            if (ld_pulse) begin
                have_lo_nx = 1'b0;
                have_hi_nx = 1'b0;
            end
            if (hit && half == HALF_HI) have_hi_nx = 1'b1;
            if (hit && half == HALF_LO) have_lo_nx = 1'b1;
        end
    end

    // Hold the staged word and the tracking flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            have_lo <= 1'b0;
            have_hi <= 1'b0;
        end else begin
            word_q  <= word_nx;
            have_lo <= have_lo_nx;
            have_hi <= have_hi_nx;
        end
    end
endmodule

// File: rtl/dacif_out_reg.sv
// Output code register for one channel. A completed pair loads the merged
// word; otherwise a load pulse copies the staged word as it stood before
// the edge. Assumes pair_done is only raised in automatic mode.
module dacif_out_reg #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_done,
    input  logic              ld_pulse,
    input  logic [CODE_W-1:0] word_nx,
    input  logic [CODE_W-1:0] word_q,
    output logic [CODE_W-1:0] code
);
    // Choose the transfer source; the automatic path has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         code <= '0;
        else if (pair_done) code <= word_nx;
        else if (ld_pulse)  code <= word_q;
    end
endmodule

// File: rtl/dual_dac_front.sv
// Two-channel converter front end. It stages byte-wide writes per channel
// and moves complete codes to the output registers, either when a pair of
// halves completes (automatic mode) or on a shared load strobe edge.
// Assumes all inputs are synchronous to clk.
module dual_dac_front
    import dacif_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int BUS_W  = DEF_BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              chan_sel,
    input  logic              byte_hi,
    input  logic [BUS_W-1:0]  din,
    input  logic              ld_strobe,
    input  logic              auto_mode,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    logic                          ld_pulse;
    logic [NUM_CH-1:0]             pair_done;
    logic [NUM_CH-1:0][CODE_W-1:0] word_q;
    logic [NUM_CH-1:0][CODE_W-1:0] word_nx;
    logic [NUM_CH-1:0][CODE_W-1:0] code_q;

    dacif_load_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_strobe (ld_strobe),
        .ld_pulse  (ld_pulse)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dacif_in_reg #(
            .CODE_W (CODE_W),
            .BUS_W  (BUS_W),
            .CH_IDX (ch)
        ) u_in (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .chan_sel  (chan_sel),
            .byte_hi   (byte_hi),
            .din       (din),
            .auto_mode (auto_mode),
            .ld_pulse  (ld_pulse),
            .word_q    (word_q[ch]),
            .word_nx   (word_nx[ch]),
            .pair_done (pair_done[ch])
        );

        dacif_out_reg #(
            .CODE_W (CODE_W)
        ) u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .pair_done (pair_done[ch]),
            .ld_pulse  (ld_pulse),
            .word_nx   (word_nx[ch]),
            .word_q    (word_q[ch]),
            .code      (code_q[ch])
        );
    end

    assign code_a = code_q[0];
    assign code_b = code_q[1];
endmodule

// File: rtl/dual_dac_front_chk.sv
// Property checker for dual_dac_front, attached by bind below.
// Observes ports and the signals passed between sub-blocks.
module dual_dac_front_chk #(
    parameter int CODE_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   auto_mode,
    input logic                   ld_strobe,
    input logic                   ld_pulse,
    input logic [1:0]             pair_done,
    input logic [1:0][CODE_W-1:0] word_q,
    input logic [1:0][CODE_W-1:0] word_nx,
    input logic [CODE_W-1:0]      code_a,
    input logic [CODE_W-1:0]      code_b
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (code_a == '0 && code_b == '0));

    a_r5_auto_load_a: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done[0] |=> code_a == $past(word_nx[0]));

    a_r5_auto_load_b: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done[1] |=> code_b == $past(word_nx[1]));

    a_r5_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_done == 2'b00 && !ld_pulse) |=> ($stable(code_a) && $stable(code_b)));

    a_r6_strobed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && !ld_pulse) |=> ($stable(code_a) && $stable(code_b)));

    a_r7_joint_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pulse && pair_done == 2'b00) |=>
            (code_a == $past(word_q[0]) && code_b == $past(word_q[1])));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse |=> !ld_pulse);

    a_r8_pulse_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse |-> ld_strobe);
endmodule

bind dual_dac_front dual_dac_front_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_mode (auto_mode),
    .ld_strobe (ld_strobe),
    .ld_pulse  (ld_pulse),
    .pair_done (pair_done),
    .word_q    (word_q),
    .word_nx   (word_nx),
    .code_a    (code_a),
    .code_b    (code_b)
);

// File: tb/dual_dac_front_test.sv
// Directed bench: one task per scenario, each checking its own results.
module dual_dac_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        chan_sel = 1'b0;
    logic        byte_hi = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        ld_strobe = 1'b0;
    logic        auto_mode = 1'b1;
    logic [11:0] code_a, code_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk; // 50 MHz

    dual_dac_front uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .chan_sel  (chan_sel),
        .byte_hi   (byte_hi),
        .din       (din),
        .ld_strobe (ld_strobe),
        .auto_mode (auto_mode),
        .code_a    (code_a),
        .code_b    (code_b)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // One write cycle; returns at the falling edge after capture.
    task automatic wr(input logic ch, input logic hi, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; chan_sel = ch; byte_hi = hi; din = d;
        @(negedge clk);
        wr_en = 1'b0; din = 8'h00;
    endtask

    task automatic t_reset();
        wr(1'b0, 1'b0, 8'h77);
        wr(1'b0, 1'b1, 8'h05);
        do_reset();
        chk("R1 code_a after reset", code_a, 12'h000);
        chk("R1 code_b after reset", code_b, 12'h000);
    endtask

    task automatic t_auto_lo_first();
        auto_mode = 1'b1;
        wr(1'b0, 1'b0, 8'h5A);
        chk("R5 single half no transfer", code_a, 12'h000);
        wr(1'b0, 1'b1, 8'hF3);
        chk("R3 high part upper bus bits ignored", code_a, 12'h35A);
        chk("R2 other channel untouched", code_b, 12'h000);
    endtask

    task automatic t_auto_hi_first();
        wr(1'b1, 1'b1, 8'h0C);
        chk("R4 high first, half only", code_b, 12'h000);
        wr(1'b1, 1'b0, 8'h21);
        chk("R4 high-first order", code_b, 12'hC21);
        chk("R2 channel A kept", code_a, 12'h35A);
    endtask

    task automatic t_auto_repeat_half();
        wr(1'b0, 1'b0, 8'h11);
        wr(1'b0, 1'b0, 8'h22);
        chk("R5 same half twice no transfer", code_a, 12'h35A);
        wr(1'b0, 1'b1, 8'hA4);
        chk("R5 pair completes with latest low", code_a, 12'h422);
    endtask

    task automatic t_strobed();
        do_reset();
        auto_mode = 1'b0;
        wr(1'b0, 1'b0, 8'hBC);
        wr(1'b0, 1'b1, 8'h09);
        wr(1'b1, 1'b1, 8'h0E);
        wr(1'b1, 1'b0, 8'hD4);
        repeat (3) @(negedge clk);
        chk("R6 channel A held", code_a, 12'h000);
        chk("R6 channel B held", code_b, 12'h000);
        @(negedge clk); ld_strobe = 1'b1;
        @(posedge clk); #1;
        chk("R7 channel A loaded", code_a, 12'h9BC);
        chk("R7 channel B loaded same edge", code_b, 12'hED4);
    endtask

    task automatic t_held_strobe();
        // ld_strobe is still high from t_strobed.
        wr(1'b0, 1'b0, 8'h55);
        repeat (2) @(negedge clk);
        chk("R8 held strobe no second transfer", code_a, 12'h9BC);
        ld_strobe = 1'b0;
        @(negedge clk); ld_strobe = 1'b1;
        @(negedge clk); ld_strobe = 1'b0;
        chk("R8 new rise transfers", code_a, 12'h955);
        chk("R7 channel B reloaded unchanged", code_b, 12'hED4);
    endtask

    task automatic t_strobed_order_and_nibble();
        wr(1'b1, 1'b1, 8'hF6);
        wr(1'b1, 1'b0, 8'h01);
        chk("R6 strobed B held after pair", code_b, 12'hED4);
        @(negedge clk); ld_strobe = 1'b1;
        @(negedge clk); ld_strobe = 1'b0;
        chk("R3 nibble from din[3:0]", code_b, 12'h601);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_auto_lo_first();
        t_auto_hi_first();
        t_auto_repeat_half();
        t_strobed();
        t_held_strobe();
        t_strobed_order_and_nibble();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule